// File: doc/BRIEF.md
# Secure Block Lookup Configuration Registers

This block is the software-visible side of a memory protection controller. It holds a table of 32-bit words in which each bit marks one block of protected memory as secure (0) or non-secure (1), a small control register, and an interrupt with two capture registers that record the first access the gating logic refused. The gating logic reads the table through a separate read port. It also uses the error-response and lockdown control bits. It reports each refused access on the capture inputs.

Software reaches the registers through a simple single-cycle access port. An access may be a byte, a halfword or a word, and it carries a secure attribute. Read data is valid in the same cycle as the access, right-aligned to bit 0. Any side effects, such as register updates and index advance, take effect at the clock edge that ends the access. The table is reached indirectly: an index register selects one word, and a data window reads or writes that word. The index can step itself after each word-sized access to the window, so a whole table can be streamed. Non-secure masters see only the identification words. A sticky lockdown bit freezes the configuration until the next reset.

The lockdown bit is a two-state machine, `LK_OPEN` and `LK_SEALED`. The only transition is `LK_OPEN` to `LK_SEALED`, taken when an accepted control write has bit 31 set. A reset returns it to `LK_OPEN`. The interrupt status is also a two-state machine, `IQ_IDLE` and `IQ_PEND`. `IQ_IDLE` moves to `IQ_PEND` on a refused-access event or a write of 1 to bit 0 of the set offset. `IQ_PEND` moves back to `IQ_IDLE` on a write of 1 to bit 0 of the clear offset.

Top module: `mpc_cfg_regs`

## Requirements
- R1: After reset, offset 0x00 reads 0x00000100, the index (0x18) reads 0, status (0x20) reads 0, enable (0x28) reads 1, both capture registers (0x2C, 0x30) read 0, and every table word reads 0.
- R2: The control register at 0x00 keeps only bit 4 (error response, output `err_resp_o`), bit 8 (index auto-step) and bit 31 (lockdown, output `locked_o`). Every other bit reads 0 whatever was written.
- R3: Offset 0x10 reads NUM_WORDS-1, and offset 0x14 reads BLK_LOG2-5.
- R4: A write to the index at 0x18 stores the written value modulo NUM_WORDS.
- R5: Offset 0x1C reads or writes the table word selected by the index. A word access (size 2) to 0x1C while bit 8 of control is set advances the index by one, and the index wraps from NUM_WORDS-1 to 0. Byte and halfword accesses do not advance the index, and no access advances it while bit 8 is clear. The table read port `lut_word` returns the word selected by `lut_sel`.
- R6: While lockdown is set, writes to 0x00, 0x1C and 0x28 have no effect, and a dropped write to 0x1C does not advance the index. Reads still work, and other registers can still be written. Only reset clears lockdown.
- R7: A non-secure access (`acc_secure`=0) to any offset below 0xFD0 reads 0 and changes nothing. Non-secure reads of 0xFD0 to 0xFFC work normally.
- R8: `acc_size` 0 is a byte on lane `acc_addr[1:0]`, size 1 is a halfword on lanes selected by `acc_addr[1]`, and sizes 2 and 3 are a full word. Write data and read data are right-aligned. A sub-word write to 0x00, 0x18 or 0x1C merges into the current contents. A sub-word write to any other register takes the unwritten bytes as 0. A sub-word read returns the addressed lanes.
- R9: Writing 1 in bit 0 of 0x34 sets interrupt status, and writing 1 in bit 0 of 0x24 clears it. A 0 in bit 0 has no effect. Both offsets read 0. Interrupt enable is bit 0 of 0x28.
- R10: A pulse on `blk_valid` while status is 0 loads 0x2C with `blk_addr` and 0x30 with {14'b0, `blk_cfg_ns`, `blk_nonsec`, `blk_master`[15:0]}, and it sets status. While status is 1, such pulses change nothing.
- R11: Offsets 0xFD0 to 0xFFC read, in ascending order, 0x04, 0x00, 0x00, 0x00, 0x60, 0xB8, 0x1B, 0x00, 0x0D, 0xF0, 0x05, 0xB1. Writes to them are ignored.
- R12: `irq_o` is high exactly when interrupt status and interrupt enable are both 1.
- R13: Reads and writes of undefined offsets return 0 and change no register or index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_valid | input | 1 | Register access in this cycle |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_secure | input | 1 | Secure attribute of the access |
| acc_size | input | 2 | 0 byte, 1 halfword, 2 or 3 word |
| acc_addr | input | 12 | Byte offset of the access |
| acc_wdata | input | 32 | Right-aligned write data |
| acc_rdata | output | 32 | Right-aligned read data, same cycle |
| lut_sel | input | IDXW | Table word selected by the gating logic |
| lut_word | output | 32 | Table word at `lut_sel` |
| err_resp_o | output | 1 | Refused accesses get an error response |
| locked_o | output | 1 | Lockdown is active |
| blk_valid | input | 1 | Gating logic refused an access |
| blk_addr | input | 32 | Address of the refused access |
| blk_master | input | 16 | Requester of the refused access |
| blk_nonsec | input | 1 | Refused access was non-secure |
| blk_cfg_ns | input | 1 | Table bit of the refused block |
| irq_o | output | 1 | Interrupt |

## Verification
The assertions assume the following about the inputs:
- There is at most one register access per cycle.
- A halfword access uses `acc_addr[0]`=0.
- Control inputs are never X once reset has been released.
- The set and clear requests come from the same single access, so they never coincide.

The stimulus meets these conditions as follows:
- It drives every access as a single-cycle pulse, set at the falling edge and removed just after the next rising edge.
- It only issues halfwords at even addresses.
- It holds every input at a defined idle value between accesses.
- It raises refused-access pulses only when no register access is in flight.

// File: rtl/mpc_cfg_pkg.sv
`timescale 1ns/1ps
package mpc_cfg_pkg;

    localparam logic [11:0] OFS_CTRL     = 12'h000;
    localparam logic [11:0] OFS_NWORDS   = 12'h010;
    localparam logic [11:0] OFS_GEOM     = 12'h014;
    localparam logic [11:0] OFS_INDEX    = 12'h018;
    localparam logic [11:0] OFS_PORT     = 12'h01C;
    localparam logic [11:0] OFS_STAT     = 12'h020;
    localparam logic [11:0] OFS_CLR      = 12'h024;
    localparam logic [11:0] OFS_EN       = 12'h028;
    localparam logic [11:0] OFS_CAP_ADDR = 12'h02C;
    localparam logic [11:0] OFS_CAP_ATTR = 12'h030;
    localparam logic [11:0] OFS_SET      = 12'h034;
    localparam logic [11:0] OFS_ID_BASE  = 12'hFD0;

    localparam int BIT_ERR  = 4;
    localparam int BIT_AINC = 8;
    localparam int BIT_LOCK = 31;

    typedef enum logic [3:0] {
        RG_NONE, RG_CTRL, RG_NWORDS, RG_GEOM, RG_INDEX, RG_PORT, RG_STAT,
        RG_CLR, RG_EN, RG_CAP_ADDR, RG_CAP_ATTR, RG_SET, RG_ID
    } reg_sel_e;

    typedef enum logic { LK_OPEN, LK_SEALED } lock_state_e;
    typedef enum logic { IQ_IDLE, IQ_PEND } irq_state_e;

    typedef struct packed {
        logic [13:0] zero;
        logic        cfg_ns;
        logic        nonsec;
        logic [15:0] master;
    } cap_attr_t;

    function automatic logic [7:0] id_byte(input logic [3:0] n);
        logic [7:0] b;
        case (n)
            4'd0:    b = 8'h04;
            4'd4:    b = 8'h60;
            4'd5:    b = 8'hB8;
            4'd6:    b = 8'h1B;
            4'd8:    b = 8'h0D;
            4'd9:    b = 8'hF0;
            4'd10:   b = 8'h05;
            4'd11:   b = 8'hB1;
            default: b = 8'h00;
        endcase
        return b;
    endfunction

endpackage

// File: rtl/mpc_acc_decode.sv
`timescale 1ns/1ps
module mpc_acc_decode
    import mpc_cfg_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        acc_valid,
    input  logic        acc_write,
    input  logic        acc_secure,
    input  logic [1:0]  acc_size,
    input  logic [11:0] acc_addr,
    input  logic [31:0] acc_wdata,
    output reg_sel_e    sel,
    output logic        rd_hit,
    output logic        wr_hit,
    output logic        is_word,
    output logic [1:0]  lane_kind,
    output logic [4:0]  rshift,
    output logic [31:0] byte_mask,
    output logic [31:0] wdata_al,
    output logic [3:0]  id_num
);
    localparam int LANES = 4;

    logic [11:0] word_ofs;
    logic [9:0]  id_off;
    logic        id_region;
    logic        allowed;
    logic [3:0]  lane_mask;

    assign word_ofs  = {acc_addr[11:2], 2'b00};
    assign id_region = (word_ofs >= OFS_ID_BASE);
    assign id_off    = word_ofs[11:2] - OFS_ID_BASE[11:2];
    assign id_num    = id_off[3:0];
    assign allowed   = acc_secure | id_region;
    assign rd_hit    = acc_valid & allowed & ~acc_write;
    assign wr_hit    = acc_valid & allowed & acc_write;

    always_comb begin
        case (word_ofs)
            OFS_CTRL:     sel = RG_CTRL;
            OFS_NWORDS:   sel = RG_NWORDS;
            OFS_GEOM:     sel = RG_GEOM;
            OFS_INDEX:    sel = RG_INDEX;
            OFS_PORT:     sel = RG_PORT;
            OFS_STAT:     sel = RG_STAT;
            OFS_CLR:      sel = RG_CLR;
            OFS_EN:       sel = RG_EN;
            OFS_CAP_ADDR: sel = RG_CAP_ADDR;
            OFS_CAP_ATTR: sel = RG_CAP_ATTR;
            OFS_SET:      sel = RG_SET;
            default:      sel = id_region ? RG_ID : RG_NONE;
        endcase
    end

    always_comb begin
        is_word   = acc_size[1];
        lane_kind = acc_size[1] ? 2'd2 : {1'b0, acc_size[0]};
        if (acc_size[1]) begin
            lane_mask = 4'b1111;
            rshift    = 5'd0;
        end else if (acc_size[0]) begin
            lane_mask = acc_addr[1] ? 4'b1100 : 4'b0011;
            rshift    = {acc_addr[1], 4'b0000};
        end else begin
            lane_mask = 4'b0001 << acc_addr[1:0];
            rshift    = {acc_addr[1:0], 3'b000};
        end
    end

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        assign byte_mask[8*i +: 8] = {8{lane_mask[i]}};
    end

    assign wdata_al = acc_wdata << rshift;

    AST_NS_LOW_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && !acc_secure && sel != RG_ID) |-> (!rd_hit && !wr_hit)); // R7

endmodule

// File: rtl/mpc_lut_bank.sv
`timescale 1ns/1ps
module mpc_lut_bank #(
    parameter int NUM_WORDS = 8,
    parameter int IDXW      = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            idx_we,
    input  logic [31:0]     idx_wval,
    input  logic            port_we,
    input  logic [31:0]     port_wval,
    input  logic            step,
    output logic [IDXW-1:0] idx_q,
    output logic [31:0]     port_word,
    input  logic [IDXW-1:0] gate_sel,
    output logic [31:0]     gate_word
);
    localparam logic [IDXW-1:0] LAST_IDX = IDXW'(NUM_WORDS - 1);
    localparam logic [IDXW:0]   NW_L     = (IDXW+1)'(NUM_WORDS);
    localparam logic [31:0]     NW32     = 32'(NUM_WORDS);

    logic [31:0]     lut_mem [NUM_WORDS];
    logic [IDXW-1:0] idx_next;

    always_comb begin
        idx_next = idx_q;
        if (idx_we)
            idx_next = IDXW'(idx_wval % NW32);
        else if (step)
            idx_next = (idx_q == LAST_IDX) ? '0 : idx_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) idx_q <= '0;
        else        idx_q <= idx_next;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int w = 0; w < NUM_WORDS; w++) lut_mem[w] <= '0;
        end else if (port_we) begin
            lut_mem[idx_q] <= port_wval;
        end
    end

    assign port_word = lut_mem[idx_q];
    assign gate_word = ({1'b0, gate_sel} < NW_L) ? lut_mem[gate_sel] : '0;

    AST_INDEX_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        ({1'b0, idx_q} < NW_L)); // R4
    AST_STEP_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !idx_we) |=> (idx_q == (($past(idx_q) == LAST_IDX) ? '0 : $past(idx_q) + 1'b1))); // R5
    AST_PORT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!port_we && !idx_we && !step) |=> $stable(port_word)); // R5

endmodule

// File: rtl/mpc_irq_capture.sv
`timescale 1ns/1ps
module mpc_irq_capture
    import mpc_cfg_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        set_req,
    input  logic        clr_req,
    input  logic        en_we,
    input  logic        en_wval,
    input  logic        blk_valid,
    input  logic [31:0] blk_addr,
    input  cap_attr_t   blk_attr,
    output logic        pend_o,
    output logic        en_q,
    output logic [31:0] cap_addr_q,
    output logic [31:0] cap_attr_q,
    output logic        irq_o
);
    irq_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            IQ_IDLE: if (blk_valid || set_req) state_d = IQ_PEND;
            IQ_PEND: if (clr_req)              state_d = IQ_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= IQ_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cap_addr_q <= '0;
            cap_attr_q <= '0;
        end else if (state_q == IQ_IDLE && blk_valid) begin
            cap_addr_q <= blk_addr;
            cap_attr_q <= blk_attr;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     en_q <= 1'b1;
        else if (en_we) en_q <= en_wval;
    end

    always_comb begin
        pend_o = (state_q == IQ_PEND);
        irq_o  = pend_o && en_q;
    end

    AST_CAPTURE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == IQ_PEND) |=> ($stable(cap_addr_q) && $stable(cap_attr_q))); // R10
    AST_CLEAR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == IQ_PEND && clr_req) |=> !pend_o); // R9
    AST_SET_RAISES: assert property (@(posedge clk) disable iff (!rst_n)
        (set_req || blk_valid) && !clr_req |=> pend_o); // R9
    AST_SET_CLR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(set_req && clr_req)); // R9

endmodule

// File: rtl/mpc_cfg_regs.sv
`timescale 1ns/1ps
module mpc_cfg_regs
    import mpc_cfg_pkg::*;
#(
    parameter int NUM_WORDS = 8,
    parameter int BLK_LOG2  = 10,
    localparam int IDXW     = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            acc_valid,
    input  logic            acc_write,
    input  logic            acc_secure,
    input  logic [1:0]      acc_size,
    input  logic [11:0]     acc_addr,
    input  logic [31:0]     acc_wdata,
    output logic [31:0]     acc_rdata,
    input  logic [IDXW-1:0] lut_sel,
    output logic [31:0]     lut_word,
    output logic            err_resp_o,
    output logic            locked_o,
    input  logic            blk_valid,
    input  logic [31:0]     blk_addr,
    input  logic [15:0]     blk_master,
    input  logic            blk_nonsec,
    input  logic            blk_cfg_ns,
    output logic            irq_o
);
    localparam logic [31:0] NWORDS_M1 = 32'(NUM_WORDS - 1);
    localparam logic [31:0] GEOM_VAL  = 32'(BLK_LOG2 - 5);

    reg_sel_e        sel;
    logic            rd_hit, wr_hit, is_word;
    logic [1:0]      lane_kind;
    logic [4:0]      rshift;
    logic [31:0]     byte_mask, wdata_al;
    logic [3:0]      id_num;

    lock_state_e     lk_q, lk_d;
    logic            err_q, ainc_q;
    logic [31:0]     ctrl_word, old_word, wval, rword, size_mask;
    logic            frozen_sel, wr_ok;
    logic            ctrl_we, idx_we, port_we, step;
    logic            set_req, clr_req, en_we;
    logic [IDXW-1:0] idx_q;
    logic [31:0]     port_word;
    logic            pend, en_q;
    logic [31:0]     cap_addr_q, cap_attr_q;
    cap_attr_t       blk_attr;

    mpc_acc_decode u_dec (
        .clk(clk), .rst_n(rst_n),
        .acc_valid(acc_valid), .acc_write(acc_write), .acc_secure(acc_secure),
        .acc_size(acc_size), .acc_addr(acc_addr), .acc_wdata(acc_wdata),
        .sel(sel), .rd_hit(rd_hit), .wr_hit(wr_hit), .is_word(is_word),
        .lane_kind(lane_kind), .rshift(rshift), .byte_mask(byte_mask),
        .wdata_al(wdata_al), .id_num(id_num)
    );

    always_comb begin
        ctrl_word           = '0;
        ctrl_word[BIT_ERR]  = err_q;
        ctrl_word[BIT_AINC] = ainc_q;
        ctrl_word[BIT_LOCK] = (lk_q == LK_SEALED);
    end

    always_comb begin
        case (sel)
            RG_CTRL:  old_word = ctrl_word;
            RG_INDEX: old_word = 32'(idx_q);
            RG_PORT:  old_word = port_word;
            default:  old_word = '0;
        endcase
        wval = (old_word & ~byte_mask) | (wdata_al & byte_mask);
    end

    assign frozen_sel = (sel == RG_CTRL) || (sel == RG_PORT) || (sel == RG_EN);
    assign wr_ok      = wr_hit && !(lk_q == LK_SEALED && frozen_sel);
    assign ctrl_we    = wr_ok && (sel == RG_CTRL);
    assign idx_we     = wr_ok && (sel == RG_INDEX);
    assign port_we    = wr_ok && (sel == RG_PORT);
    assign en_we      = wr_ok && (sel == RG_EN);
    assign set_req    = wr_ok && (sel == RG_SET) && wval[0];
    assign clr_req    = wr_ok && (sel == RG_CLR) && wval[0];
    assign step       = (sel == RG_PORT) && is_word && ainc_q && (rd_hit || port_we);

    always_comb begin
        lk_d = lk_q;
        unique case (lk_q)
            LK_OPEN:   if (ctrl_we && wval[BIT_LOCK]) lk_d = LK_SEALED;
            LK_SEALED: lk_d = LK_SEALED;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lk_q <= LK_OPEN;
        else        lk_q <= lk_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            err_q  <= 1'b0;
            ainc_q <= 1'b1;
        end else if (ctrl_we) begin
            err_q  <= wval[BIT_ERR];
            ainc_q <= wval[BIT_AINC];
        end
    end

    assign err_resp_o = err_q;
    assign locked_o   = (lk_q == LK_SEALED);

    mpc_lut_bank #(.NUM_WORDS(NUM_WORDS), .IDXW(IDXW)) u_lut (
        .clk(clk), .rst_n(rst_n),
        .idx_we(idx_we), .idx_wval(wval),
        .port_we(port_we), .port_wval(wval),
        .step(step), .idx_q(idx_q), .port_word(port_word),
        .gate_sel(lut_sel), .gate_word(lut_word)
    );

    always_comb begin
        blk_attr        = '0;
        blk_attr.cfg_ns = blk_cfg_ns;
        blk_attr.nonsec = blk_nonsec;
        blk_attr.master = blk_master;
    end

    mpc_irq_capture u_irq (
        .clk(clk), .rst_n(rst_n),
        .set_req(set_req), .clr_req(clr_req),
        .en_we(en_we), .en_wval(wval[0]),
        .blk_valid(blk_valid), .blk_addr(blk_addr), .blk_attr(blk_attr),
        .pend_o(pend), .en_q(en_q),
        .cap_addr_q(cap_addr_q), .cap_attr_q(cap_attr_q),
        .irq_o(irq_o)
    );

    always_comb begin
        case (sel)
            RG_CTRL:     rword = ctrl_word;
            RG_NWORDS:   rword = NWORDS_M1;
            RG_GEOM:     rword = GEOM_VAL;
            RG_INDEX:    rword = 32'(idx_q);
            RG_PORT:     rword = port_word;
            RG_STAT:     rword = {31'b0, pend};
            RG_EN:       rword = {31'b0, en_q};
            RG_CAP_ADDR: rword = cap_addr_q;
            RG_CAP_ATTR: rword = cap_attr_q;
            RG_ID:       rword = {24'b0, id_byte(id_num)};
            default:     rword = '0;
        endcase
        case (lane_kind)
            2'd0:    size_mask = 32'h0000_00FF;
            2'd1:    size_mask = 32'h0000_FFFF;
            default: size_mask = 32'hFFFF_FFFF;
        endcase
        acc_rdata = rd_hit ? ((rword >> rshift) & size_mask) : '0;
    end

    AST_LOCK_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_q == LK_SEALED) |=> (locked_o && $stable(err_q) && $stable(ainc_q) && $stable(en_q))); // R6
    AST_NS_WRITE_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_write && !acc_secure) |=> ($stable(ctrl_word) && $stable(en_q) && $stable(idx_q))); // R7
    AST_LOCKED_PORT_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (locked_o && !idx_we && !step) |=> $stable(port_word)); // R6

endmodule

// File: tb/sim_mpc_cfg_regs.sv
`timescale 1ns/1ps
module sim_mpc_cfg_regs;
    localparam int NW   = 8;
    localparam int BL2  = 10;
    localparam int IDXW = 3;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            acc_valid = 0, acc_write = 0, acc_secure = 0;
    logic [1:0]      acc_size = 0;
    logic [11:0]     acc_addr = 0;
    logic [31:0]     acc_wdata = 0;
    logic [31:0]     acc_rdata;
    logic [IDXW-1:0] lut_sel = 0;
    logic [31:0]     lut_word;
    logic            err_resp_o, locked_o, irq_o;
    logic            blk_valid = 0, blk_nonsec = 0, blk_cfg_ns = 0;
    logic [31:0]     blk_addr = 0;
    logic [15:0]     blk_master = 0;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    mpc_cfg_regs #(.NUM_WORDS(NW), .BLK_LOG2(BL2)) u0 (
        .clk(clk), .rst_n(rst_n),
        .acc_valid(acc_valid), .acc_write(acc_write), .acc_secure(acc_secure),
        .acc_size(acc_size), .acc_addr(acc_addr), .acc_wdata(acc_wdata),
        .acc_rdata(acc_rdata), .lut_sel(lut_sel), .lut_word(lut_word),
        .err_resp_o(err_resp_o), .locked_o(locked_o),
        .blk_valid(blk_valid), .blk_addr(blk_addr), .blk_master(blk_master),
        .blk_nonsec(blk_nonsec), .blk_cfg_ns(blk_cfg_ns), .irq_o(irq_o)
    );

    task automatic chk(input string req, input string what, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s: actual 0x%08h expected 0x%08h", req, what, got, exp);
        end
    endtask

    task automatic acc(input logic wr, input logic sec, input logic [1:0] sz,
                       input logic [11:0] a, input logic [31:0] d, output logic [31:0] q);
        @(negedge clk);
        acc_valid = 1; acc_write = wr; acc_secure = sec; acc_size = sz;
        acc_addr = a; acc_wdata = d;
        #1 q = acc_rdata;
        @(posedge clk);
        #1 acc_valid = 0; acc_write = 0; acc_secure = 0;
    endtask

    task automatic wr32(input logic [11:0] a, input logic [31:0] d);
        logic [31:0] q;
        acc(1'b1, 1'b1, 2'd2, a, d, q);
    endtask

    task automatic rd32(input logic [11:0] a, output logic [31:0] q);
        acc(1'b0, 1'b1, 2'd2, a, 32'h0, q);
    endtask

    task automatic wrs(input logic [1:0] sz, input logic [11:0] a, input logic [31:0] d);
        logic [31:0] q;
        acc(1'b1, 1'b1, sz, a, d, q);
    endtask

    task automatic rds(input logic [1:0] sz, input logic [11:0] a, output logic [31:0] q);
        acc(1'b0, 1'b1, sz, a, 32'h0, q);
    endtask

    task automatic rchk(input string req, input logic [11:0] a, input logic [31:0] exp);
        logic [31:0] q;
        rd32(a, q);
        chk(req, $sformatf("read 0x%03h", a), q, exp);
    endtask

    task automatic do_reset();
        rst_n = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
    endtask

    task automatic blk_pulse(input logic [31:0] a, input logic [15:0] m, input logic ns, input logic cfg);
        @(negedge clk);
        blk_valid = 1; blk_addr = a; blk_master = m; blk_nonsec = ns; blk_cfg_ns = cfg;
        @(posedge clk);
        #1 blk_valid = 0;
    endtask

    task automatic t_reset();
        logic [31:0] q;
        rchk("R1", 12'h000, 32'h0000_0100);
        rchk("R1", 12'h018, 32'h0);
        rchk("R1", 12'h020, 32'h0);
        rchk("R1", 12'h028, 32'h1);
        rchk("R1", 12'h02C, 32'h0);
        rchk("R1", 12'h030, 32'h0);
        wr32(12'h000, 32'h0);
        for (int w = 0; w < NW; w++) begin
            wr32(12'h018, w);
            rd32(12'h01C, q);
            chk("R1", "table word", q, 32'h0);
        end
        #1 chk("R1", "irq after reset", {31'b0, irq_o}, 32'h0);
    endtask

    task automatic t_geometry();
        rchk("R3", 12'h010, NW - 1);
        rchk("R3", 12'h014, BL2 - 5);
    endtask

    task automatic t_ctrl();
        wr32(12'h000, 32'h7FFF_FFFF);
        rchk("R2", 12'h000, 32'h0000_0110);
        #1 chk("R2", "err_resp_o", {31'b0, err_resp_o}, 32'h1);
        wr32(12'h000, 32'h0);
        rchk("R2", 12'h000, 32'h0);
    endtask

    task automatic t_index();
        wr32(12'h018, 32'd13);
        rchk("R4", 12'h018, 32'd5);
        wr32(12'h018, NW);
        rchk("R4", 12'h018, 32'd0);
    endtask

    task automatic t_autostep();
        logic [31:0] q;
        wr32(12'h000, 32'h100);
        wr32(12'h018, 6);
        wr32(12'h01C, 32'hA0);
        rchk("R5", 12'h018, 7);
        wr32(12'h01C, 32'hA1);
        rchk("R5", 12'h018, 0);
        wr32(12'h018, 6);
        rchk("R5", 12'h01C, 32'hA0);
        rchk("R5", 12'h018, 7);
        rds(2'd0, 12'h01C, q);
        chk("R5", "byte read of port", q, 32'hA1);
        rchk("R5", 12'h018, 7);
        wr32(12'h000, 32'h0);
        wr32(12'h018, 0);
        wr32(12'h01C, 32'hC0);
        rchk("R5", 12'h018, 0);
        @(negedge clk); lut_sel = 6; #1 chk("R5", "lut_word[6]", lut_word, 32'hA0);
        @(negedge clk); lut_sel = 7; #1 chk("R5", "lut_word[7]", lut_word, 32'hA1);
        @(negedge clk); lut_sel = 0; #1 chk("R5", "lut_word[0]", lut_word, 32'hC0);
    endtask

    task automatic t_subword();
        logic [31:0] q;
        wr32(12'h000, 32'h0);
        wr32(12'h018, 2);
        wr32(12'h01C, 32'h1122_3344);
        wrs(2'd0, 12'h01E, 32'hAA);
        rchk("R8", 12'h01C, 32'h11AA_3344);
        wrs(2'd1, 12'h01E, 32'hBEEF);
        rchk("R8", 12'h01C, 32'hBEEF_3344);
        rds(2'd0, 12'h01D, q);
        chk("R8", "byte lane 1", q, 32'h33);
        rds(2'd1, 12'h01E, q);
        chk("R8", "upper half", q, 32'hBEEF);
        rds(2'd1, 12'h01C, q);
        chk("R8", "lower half", q, 32'h3344);
        wrs(2'd0, 12'h001, 32'h01);
        rchk("R8", 12'h000, 32'h100);
        wrs(2'd0, 12'h000, 32'h10);
        rchk("R8", 12'h000, 32'h110);
        wr32(12'h000, 32'h0);
        wrs(2'd0, 12'h029, 32'hFF);
        rchk("R8", 12'h028, 32'h0);
        wr32(12'h028, 32'h1);
    endtask

    task automatic t_irq();
        wr32(12'h034, 32'h1);
        rchk("R9", 12'h020, 32'h1);
        #1 chk("R12", "irq set+en", {31'b0, irq_o}, 32'h1);
        rchk("R9", 12'h034, 32'h0);
        rchk("R9", 12'h024, 32'h0);
        wr32(12'h028, 32'h0);
        #1 chk("R12", "irq disabled", {31'b0, irq_o}, 32'h0);
        rchk("R9", 12'h020, 32'h1);
        wr32(12'h028, 32'h1);
        #1 chk("R12", "irq re-enabled", {31'b0, irq_o}, 32'h1);
        wr32(12'h024, 32'h2);
        rchk("R9", 12'h020, 32'h1);
        wr32(12'h024, 32'h1);
        rchk("R9", 12'h020, 32'h0);
        #1 chk("R12", "irq cleared", {31'b0, irq_o}, 32'h0);
        wr32(12'h034, 32'h2);
        rchk("R9", 12'h020, 32'h0);
    endtask

    task automatic t_capture();
        blk_pulse(32'h1234_5670, 16'h00AB, 1'b1, 1'b0);
        rchk("R10", 12'h02C, 32'h1234_5670);
        rchk("R10", 12'h030, 32'h0001_00AB);
        rchk("R10", 12'h020, 32'h1);
        #1 chk("R12", "irq on capture", {31'b0, irq_o}, 32'h1);
        blk_pulse(32'hFFFF_0000, 16'h7777, 1'b0, 1'b1);
        rchk("R10", 12'h02C, 32'h1234_5670);
        rchk("R10", 12'h030, 32'h0001_00AB);
        wr32(12'h024, 32'h1);
        blk_pulse(32'h0000_0040, 16'h0055, 1'b0, 1'b1);
        rchk("R10", 12'h02C, 32'h0000_0040);
        rchk("R10", 12'h030, 32'h0002_0055);
        wr32(12'h024, 32'h1);
    endtask

    task automatic t_nonsecure();
        logic [31:0] q;
        wr32(12'h000, 32'h110);
        wr32(12'h018, 2);
        acc(1'b1, 1'b0, 2'd2, 12'h018, 32'h5, q);
        rchk("R7", 12'h018, 2);
        acc(1'b1, 1'b0, 2'd2, 12'h000, 32'h0, q);
        rchk("R7", 12'h000, 32'h110);
        acc(1'b0, 1'b0, 2'd2, 12'h000, 32'h0, q);
        chk("R7", "ns read ctrl", q, 32'h0);
        acc(1'b0, 1'b0, 2'd2, 12'h018, 32'h0, q);
        chk("R7", "ns read index", q, 32'h0);
        acc(1'b0, 1'b0, 2'd2, 12'hFE0, 32'h0, q);
        chk("R7", "ns read id", q, 32'h60);
    endtask

    task automatic t_id();
        logic [7:0] exp_id [12] = '{8'h04, 8'h00, 8'h00, 8'h00, 8'h60, 8'hB8,
                                    8'h1B, 8'h00, 8'h0D, 8'hF0, 8'h05, 8'hB1};
        for (int k = 0; k < 12; k++)
            rchk("R11", 12'hFD0 + 12'(4 * k), {24'b0, exp_id[k]});
        wr32(12'hFD0, 32'hFF);
        rchk("R11", 12'hFD0, 32'h04);
    endtask

    task automatic t_undef();
        wr32(12'h000, 32'h100);
        wr32(12'h018, 3);
        rchk("R13", 12'h004, 32'h0);
        rchk("R13", 12'h200, 32'h0);
        wr32(12'h008, 32'hFFFF_FFFF);
        rchk("R13", 12'h000, 32'h100);
        rchk("R13", 12'h018, 3);
    endtask

    task automatic t_lock();
        logic [31:0] q;
        wr32(12'h028, 32'h1);
        wr32(12'h000, 32'h8000_0100);
        rchk("R6", 12'h000, 32'h8000_0100);
        #1 chk("R6", "locked_o", {31'b0, locked_o}, 32'h1);
        wr32(12'h000, 32'h0);
        rchk("R6", 12'h000, 32'h8000_0100);
        wr32(12'h018, 1);
        wr32(12'h01C, 32'hDEAD);
        rchk("R6", 12'h018, 1);
        wr32(12'h028, 32'h0);
        rchk("R6", 12'h028, 32'h1);
        rd32(12'h01C, q);
        chk("R6", "locked port read", q, 32'h0);
        rchk("R6", 12'h018, 2);
        do_reset();
        rchk("R6", 12'h000, 32'h100);
        #1 chk("R6", "locked_o after reset", {31'b0, locked_o}, 32'h0);
    endtask

    initial begin
        do_reset();
        t_reset();
        t_geometry();
        t_ctrl();
        t_index();
        t_autostep();
        t_subword();
        t_irq();
        t_capture();
        t_nonsecure();
        t_id();
        t_undef();
        t_lock();
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule